// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital controller of a 16-bit successive-approximation converter. A falling edge on the start input begins a conversion. The block raises a busy flag and runs a gated bit clock. On each bit period it drives one trial bit low in a complementary result word, with the most significant bit first. It also samples a single keep/reject comparator input to settle the bit tried in the period before. The analog side (DAC, comparator, reference) lives outside the block. In this project it is modelled by the testbench.

A 3-bit resolution select, captured when a conversion starts, ends the sequence early after 16, 15, 14, 13, 12, 10 or 8 bits. This shortens the busy time. The result word is complementary binary: a logic 0 in the word marks a code bit of 1. A second output gives the same word with its MSB inverted, which is the complementary two's-complement view for bipolar ranges. The result stays on the outputs until the next conversion starts. The busy flag falls half a bit period after the last data change, so a consumer can latch the word on the falling edge of the busy flag.

Top module: `sar_seq`

## Requirements
- R1: A conversion is launched when `conv_start` is seen high at one rising clock edge and low at the next. `status` is high from the cycle after that edge, and `bit_clk` gives exactly N+1 one-cycle high pulses during the conversion, where N is the selected resolution.
- R2: At launch, every bit of `data_n` is set to 1.
- R3: The bit clock's first pulse coincides with the MSB (`data_n[15]`) being driven to 0 with all other bits still 1. Each later pulse drives the next lower bit to 0.
- R4: At each bit-clock pulse after the first, `comp_keep` is sampled. A value of 1 (keep) leaves the bit tried in the previous period at 0. A value of 0 (reject) returns it to 1. With an ideal comparator that keeps when the inverted trial word is at or below the input code, the final `~data_n` equals the input code truncated to N bits.
- R5: `res_sel` encodes the resolution as 0:16, 1:15, 2:14, 3:13, 4:12, 5:10, 6:8 and 7:16. The bits below position N stay at 1. `status` is high for exactly 2N+2 clock cycles.
- R6: `bit_clk` is low whenever `status` is low. The last `bit_clk` pulse is high in the cycle just before `status` falls.
- R7: `data_n` changes only at edges where `bit_clk` rises or a conversion is launched. After `status` falls it holds its value whatever `comp_keep` does.
- R8: A falling edge of `conv_start` while `status` is high is ignored: the conversion's length and result are unchanged.
- R9: `data_ctc` equals `data_n` with bit 15 inverted.
- R10: After reset, `status` and `bit_clk` are 0 and `data_n` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; two cycles form one bit period |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Convert command; its falling edge launches a conversion |
| res_sel | input | 3 | Resolution select, captured at launch |
| comp_keep | input | 1 | Comparator decision: 1 keeps the trial bit, 0 rejects it |
| status | output | 1 | High while a conversion is in progress |
| bit_clk | output | 1 | Gated bit clock, parked low between conversions |
| data_n | output | 16 | Complementary result word |
| data_ctc | output | 16 | Result word with the MSB inverted |

## Verification
The assertions assume that `conv_start` is synchronous to `clk` and that `res_sel` only changes while no conversion is running. The bench drives both at falling clock edges and sets `res_sel` before each launch. The ideal comparator is combinational from `data_n`, so it is stable for a full bit period before it is sampled. One test deliberately pulses `conv_start` in the middle of a conversion, outside the allowed use, to show that such a pulse has no effect.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic {
    PH_EDGE = 1'b0,
    PH_HOLD = 1'b1
  } phase_e;

  // Number of bits converted for a given resolution select and full width.
  function automatic int unsigned res_width(input logic [2:0] sel, input int unsigned w);
    case (sel)
      3'd1:    return w - 1;
      3'd2:    return w - 2;
      3'd3:    return w - 3;
      3'd4:    return w - 4;
      3'd5:    return w - 6;
      3'd6:    return w - 8;
      default: return w;
    endcase
  endfunction

endpackage

// File: rtl/sar_start_detect.sv
module sar_start_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_start,
  input  logic busy,
  output logic start_fall,
  output logic launch
);

  logic start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= conv_start;
  end

  assign start_fall = start_q & ~conv_start;
  assign launch     = start_fall & ~busy;

endmodule

// File: rtl/sar_step_timer.sv
module sar_step_timer
  import sar_seq_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned SW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [2:0]    res_sel,
  output logic          status,
  output logic          bit_clk,
  output logic          tick,
  output logic          last,
  output logic [SW-1:0] step,
  output logic [SW-1:0] nbits
);

  phase_e        phase_q;
  logic          status_q;
  logic          bit_clk_q;
  logic [SW-1:0] step_q;
  logic [SW-1:0] nbits_q;

  assign tick = status_q & (phase_q == PH_EDGE);
  assign last = status_q & (phase_q == PH_HOLD) & (step_q == nbits_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= 1'b0;
      bit_clk_q <= 1'b0;
      phase_q   <= PH_EDGE;
      step_q    <= '0;
      nbits_q   <= SW'(W);
    end else if (launch) begin
      status_q  <= 1'b1;
      bit_clk_q <= 1'b0;
      phase_q   <= PH_EDGE;
      step_q    <= '0;
      nbits_q   <= SW'(res_width(res_sel, W));
    end else if (status_q) begin
      bit_clk_q <= tick;
      phase_q   <= (phase_q == PH_EDGE) ? PH_HOLD : PH_EDGE;
      if (phase_q == PH_HOLD) begin
        if (step_q == nbits_q) status_q <= 1'b0;
        else                   step_q   <= step_q + 1'b1;
      end
    end
  end

  assign status  = status_q;
  assign bit_clk = bit_clk_q;
  assign step    = step_q;
  assign nbits   = nbits_q;

endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg #(
  parameter int unsigned W  = 16,
  parameter int unsigned SW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          tick,
  input  logic          comp_keep,
  input  logic [SW-1:0] step,
  input  logic [SW-1:0] nbits,
  output logic [W-1:0]  data_n
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam int unsigned BITNUM = W - i;  // 1 = MSB
    logic trial_hit;
    logic dec_hit;
    logic q;

    assign trial_hit = tick && (step == SW'(BITNUM - 1)) && (step < nbits);
    assign dec_hit   = tick && (step == SW'(BITNUM));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= 1'b1;
      else if (launch)    q <= 1'b1;
      else if (trial_hit) q <= 1'b0;
      else if (dec_hit)   q <= ~comp_keep;
    end

    assign data_n[i] = q;
  end

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_start,
  input  logic [2:0]   res_sel,
  input  logic         comp_keep,
  output logic         status,
  output logic         bit_clk,
  output logic [W-1:0] data_n,
  output logic [W-1:0] data_ctc
);

  localparam int unsigned SW = $clog2(W + 1);

  logic          start_fall_w;
  logic          launch_w;
  logic          tick_w;
  logic          last_w;
  logic [SW-1:0] step_w;
  logic [SW-1:0] nbits_w;

  sar_start_detect u_start (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_start(conv_start),
    .busy      (status),
    .start_fall(start_fall_w),
    .launch    (launch_w)
  );

  sar_step_timer #(.W(W), .SW(SW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch_w),
    .res_sel(res_sel),
    .status (status),
    .bit_clk(bit_clk),
    .tick   (tick_w),
    .last   (last_w),
    .step   (step_w),
    .nbits  (nbits_w)
  );

  sar_bit_reg #(.W(W), .SW(SW)) u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch_w),
    .tick     (tick_w),
    .comp_keep(comp_keep),
    .step     (step_w),
    .nbits    (nbits_w),
    .data_n   (data_n)
  );

  assign data_ctc = {~data_n[W-1], data_n[W-2:0]};

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         status,
  input logic         bit_clk,
  input logic [W-1:0] data_n,
  input logic         launch,
  input logic         start_fall,
  input logic         last
);

  // R6: clock parked low while idle
  p_clk_parked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !status |-> !bit_clk);

  // R6: the final pulse sits just before status falls
  p_status_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status) |-> $past(bit_clk));

  // R1: each bit-clock pulse lasts one cycle
  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_clk |=> !bit_clk);

  // R2: launch initializes the word and raises status
  p_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (status && (data_n == '1)));

  // R7: idle data holds unless a conversion launches
  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!status && !launch) |=> $stable(data_n));

  // R7: during a conversion data moves only with a bit-clock rise
  p_data_on_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status |=> ($stable(data_n) || $rose(bit_clk)));

  // R8: a start edge during a conversion does not end or restart it
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status && start_fall && !last) |=> (status && !bit_clk || status && $past(!bit_clk)));

endmodule

bind sar_seq sar_seq_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .status    (status),
  .bit_clk   (bit_clk),
  .data_n    (data_n),
  .launch    (launch_w),
  .start_fall(start_fall_w),
  .last      (last_w)
);

// File: tb/test_sar_seq.sv
module test_sar_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        conv_start;
  logic [2:0]  res_sel;
  logic [15:0] vin;
  logic        comp_keep;
  logic        status;
  logic        bit_clk;
  logic [15:0] data_n;
  logic [15:0] data_ctc;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  // Ideal DAC + comparator: keep while the trial code does not exceed the input.
  assign comp_keep = ((~data_n) <= vin);

  sar_seq i_sar_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_start(conv_start),
    .res_sel   (res_sel),
    .comp_keep (comp_keep),
    .status    (status),
    .bit_clk   (bit_clk),
    .data_n    (data_n),
    .data_ctc  (data_ctc)
  );

  // {res_sel, input code}
  localparam logic [18:0] VEC [12] = '{
    {3'd0, 16'h0000}, {3'd0, 16'hFFFF}, {3'd0, 16'h8000}, {3'd0, 16'h7FFF},
    {3'd0, 16'h1234}, {3'd1, 16'hA5A5}, {3'd2, 16'h3C71}, {3'd3, 16'hC3C3},
    {3'd4, 16'hFFFF}, {3'd5, 16'h8001}, {3'd6, 16'h00FF}, {3'd7, 16'h5555}
  };

  function automatic int bits_for(input logic [2:0] s);
    int n;
    n = 16;
    if (s == 3'd1) n = 15;
    if (s == 3'd2) n = 14;
    if (s == 3'd3) n = 13;
    if (s == 3'd4) n = 12;
    if (s == 3'd5) n = 10;
    if (s == 3'd6) n = 8;
    return n;
  endfunction

  function automatic logic [15:0] model_word(input logic [2:0] s, input logic [15:0] v);
    logic [15:0] keep_mask;
    keep_mask = 16'hFFFF << (16 - bits_for(s));
    return ~(v & keep_mask);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_conv(input logic [2:0] s, input logic [15:0] v, input bit poke,
                          output int busy, output int pulses);
    res_sel = s;
    vin     = v;
    @(negedge clk) conv_start = 1'b1;
    @(negedge clk) conv_start = 1'b0;
    busy   = 0;
    pulses = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (poke && busy == 6) conv_start = 1'b1;
      if (poke && busy == 8) conv_start = 1'b0;
      if (status)  busy++;
      if (bit_clk) pulses++;
      if (!status) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int busy;
    int pulses;
    logic [15:0] held;
    rst_n      = 1'b0;
    conv_start = 1'b0;
    res_sel    = 3'd0;
    vin        = 16'h0000;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(status == 1'b0,      "R10 status", 32'(status), 0);
    check(bit_clk == 1'b0,     "R10 bit_clk", 32'(bit_clk), 0);
    check(data_n == 16'hFFFF,  "R10 data_n", 32'(data_n), 32'hFFFF);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk: R1 R4 R5 R6 R9
    foreach (VEC[k]) begin
      run_conv(VEC[k][18:16], VEC[k][15:0], 1'b0, busy, pulses);
      check(busy == 2 * bits_for(VEC[k][18:16]) + 2, "R5 busy length", 32'(busy),
            32'(2 * bits_for(VEC[k][18:16]) + 2));
      check(pulses == bits_for(VEC[k][18:16]) + 1, "R1 pulse count", 32'(pulses),
            32'(bits_for(VEC[k][18:16]) + 1));
      check(data_n == model_word(VEC[k][18:16], VEC[k][15:0]), "R4 R5 result",
            32'(data_n), 32'(model_word(VEC[k][18:16], VEC[k][15:0])));
      check(data_ctc == (data_n ^ 16'h8000), "R9 ctc view", 32'(data_ctc),
            32'(data_n ^ 16'h8000));
      check(bit_clk == 1'b0, "R6 parked", 32'(bit_clk), 0);
    end

    // R2 / R3: initialization and MSB-first trial
    res_sel = 3'd0;
    vin     = 16'h4000;
    @(negedge clk) conv_start = 1'b1;
    @(negedge clk) conv_start = 1'b0;
    @(negedge clk);
    check(status == 1'b1 && data_n == 16'hFFFF && bit_clk == 1'b0, "R2 init word",
          32'(data_n), 32'hFFFF);
    @(negedge clk);
    check(data_n == 16'h7FFF && bit_clk == 1'b1, "R3 MSB trial", 32'(data_n), 32'h7FFF);
    repeat (2) @(negedge clk);
    // MSB rejected (0x8000 > 0x4000), bit 2 now tried
    check(data_n == 16'hBFFF, "R3 R4 reject then next trial", 32'(data_n), 32'hBFFF);
    while (status) @(negedge clk);
    check(data_n == 16'hBFFF, "R4 final", 32'(data_n), 32'hBFFF);

    // R7: result held after status falls, comparator ignored
    held = data_n;
    vin  = 16'hFFFF;
    repeat (20) @(negedge clk);
    check(data_n == held, "R7 hold", 32'(data_n), 32'(held));

    // R8: start pulse during a conversion ignored
    run_conv(3'd6, 16'h9A00, 1'b1, busy, pulses);
    check(busy == 18, "R8 busy unchanged", 32'(busy), 18);
    check(data_n == model_word(3'd6, 16'h9A00), "R8 result unchanged", 32'(data_n),
          32'(model_word(3'd6, 16'h9A00)));
    repeat (4) @(negedge clk);
    check(status == 1'b0, "R8 no relaunch", 32'(status), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule